// File: doc/BRIEF.md
# Control Register Access Decoder

This block decides, for each processor cycle, whether the cycle goes to the memory controller's internal register space. It also picks which of three routes carries the cycle there. The first route is a direct hit on the controller's register base. The second is an alias window inside the integrated graphics MMIO range. The third is a separate register base for the thermal monitor. The block turns the cycle address into a register offset for the chosen route. It also says whether the access is accepted or refused.

The cycle address, the read/write flag, the memory-cycle flag and the function number are presented with a valid strobe, and the block reads configuration enables and base addresses as static inputs. One clock later the block returns:
- a route code, where 0 means no route, 1 means direct, 2 means graphics alias and 3 means thermal;
- an offset;
- an accept flag;
- a reject flag.

The register base covers a 32 KB naturally aligned window. The graphics MMIO base covers a 4 MB window. The thermal base covers a 4 KB window. In each case only the base bits above the window size are compared. The block does not handle I/O-port indirection and does not contain the register file.

Top module: `regacc_decoder`

## Requirements
- R1: A valid memory cycle with the register base enable set, whose address bits above bit 14 equal those of the register base, yields route 1 and offset = address[14:0] in the following cycle.
- R2: The direct route of R1 works for a register base and address above 4 GB (bit 32 or higher set) exactly as below it.
- R3: A valid memory cycle whose address lies at graphics-window offsets 0x10000 to 0x13FFF yields route 2 and offset = address − graphics base − 0x10000. Three conditions must also hold: the graphics device is enabled, its memory decoding is enabled, and the function number is 0.
- R4: If any one condition of R3 is missing (device enable, memory enable, function 0, or window offset inside 0x10000–0x13FFF), the alias route is not taken.
- R5: On the alias route with the register base enable clear, reads are accepted. A write is refused: route 0, accept 0, reject 1. With the enable set, alias writes are accepted.
- R6: A valid memory cycle whose address bits above bit 11 equal those of the thermal base yields route 3 and offset = address[11:0], independent of every enable.
- R7: Priority is direct over alias over thermal. A refused alias write is not passed on to the thermal route.
- R8: A cycle with the valid or memory flag clear yields route 0, offset 0, accept 0 and reject 0.
- R9: All outputs are registered with one cycle of latency. While reset is high they are route 0, offset 0, accept 0 and reject 0.
- R10: Reject is high only in the cycle after a refused request. It is never high together with accept. Accept is high exactly when the route is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Cycle present this clock |
| req_mem | input | 1 | Cycle is a processor memory cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (40) | Cycle address |
| req_func | input | FUNC_W (3) | Target function number within the graphics device |
| cfg_reg_en | input | 1 | Register base enable |
| cfg_reg_base | input | ADDR_W | Register base (bits above bit 14 compared) |
| cfg_gfx_en | input | 1 | Graphics device enabled |
| cfg_gfx_mem_en | input | 1 | Graphics memory decoding enabled |
| cfg_gfx_base | input | ADDR_W | Graphics MMIO base (bits above bit 21 compared) |
| cfg_tm_base | input | ADDR_W | Thermal register base (bits above bit 11 compared) |
| out_sel | output | 2 | Route: 0 none, 1 direct, 2 alias, 3 thermal |
| out_offset | output | OFF_W (15) | Register offset for the chosen route |
| out_allow | output | 1 | Access accepted |
| out_reject | output | 1 | Access refused |

## Verification
A single cycle can hit more than one route at once. The bench provokes this with a second base layout that places the register base and the thermal base inside the graphics alias window. Every address is then swept against every combination of enables, the write flag and the function number. The bench judges each outcome against a priority model built from R7. It also checks that a refused alias write lands on neither of the lower routes.

// File: rtl/regacc_pkg.sv
package regacc_pkg;

    typedef enum logic [1:0] {
        PATH_NONE    = 2'd0,
        PATH_DIRECT  = 2'd1,
        PATH_ALIAS   = 2'd2,
        PATH_THERMAL = 2'd3
    } path_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/regacc_win_match.sv
module regacc_win_match #(
    parameter int ADDR_W = 40,
    parameter int WIN_W  = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    output logic              hit,
    output logic [WIN_W-1:0]  offset
);
    // Naturally aligned window: only bits above the window size are compared.
    assign hit    = (addr[ADDR_W-1:WIN_W] == base[ADDR_W-1:WIN_W]);
    assign offset = addr[WIN_W-1:0];
endmodule

// File: rtl/regacc_alias_gate.sv
module regacc_alias_gate #(
    parameter int          GFX_WIN_W = 22,
    parameter int          ALIAS_W   = 14,
    parameter logic [31:0] ALIAS_LO  = 32'h0001_0000,
    parameter int          FUNC_W    = 3
) (
    input  logic                 cyc_ok,
    input  logic                 gfx_hit,
    input  logic [GFX_WIN_W-1:0] gfx_off,
    input  logic                 gfx_en,
    input  logic                 gfx_mem_en,
    input  logic [FUNC_W-1:0]    func,
    input  logic                 write,
    input  logic                 reg_en,
    output logic                 match,
    output logic                 refuse,
    output logic [ALIAS_W-1:0]   alias_off
);
    localparam logic [GFX_WIN_W-1:0] LO  = GFX_WIN_W'(ALIAS_LO);
    localparam logic [GFX_WIN_W-1:0] HI  = GFX_WIN_W'(ALIAS_LO + (32'd1 << ALIAS_W) - 32'd1);

    logic                 in_win;
    logic [GFX_WIN_W-1:0] rel;

    assign in_win    = gfx_hit && (gfx_off >= LO) && (gfx_off <= HI);
    assign rel       = gfx_off - LO;
    assign alias_off = rel[ALIAS_W-1:0];
    assign match     = cyc_ok && in_win && gfx_en && gfx_mem_en && (func == '0);
    // With the register base disabled the alias is read-only.
    assign refuse    = match && write && !reg_en;
endmodule

// File: rtl/regacc_decoder.sv
module regacc_decoder
    import regacc_pkg::*;
#(
    parameter int          ADDR_W    = 40,
    parameter int          REG_WIN_W = 15,
    parameter int          GFX_WIN_W = 22,
    parameter int          TM_WIN_W  = 12,
    parameter int          ALIAS_W   = 14,
    parameter logic [31:0] ALIAS_LO  = 32'h0001_0000,
    parameter int          FUNC_W    = 3,
    parameter int          OFF_W     = max3(REG_WIN_W, ALIAS_W, TM_WIN_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_mem,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [FUNC_W-1:0] req_func,
    input  logic              cfg_reg_en,
    input  logic [ADDR_W-1:0] cfg_reg_base,
    input  logic              cfg_gfx_en,
    input  logic              cfg_gfx_mem_en,
    input  logic [ADDR_W-1:0] cfg_gfx_base,
    input  logic [ADDR_W-1:0] cfg_tm_base,
    output logic [1:0]        out_sel,
    output logic [OFF_W-1:0]  out_offset,
    output logic              out_allow,
    output logic              out_reject
);
    typedef struct packed {
        path_e            path;
        logic [OFF_W-1:0] offset;
        logic             allow;
        logic             reject;
    } decode_t;

    logic                 cyc_ok;
    logic                 reg_hit, gfx_hit, tm_hit;
    logic [REG_WIN_W-1:0] reg_off;
    logic [GFX_WIN_W-1:0] gfx_off;
    logic [TM_WIN_W-1:0]  tm_off;
    logic                 al_match, al_refuse;
    logic [ALIAS_W-1:0]   al_off;
    decode_t              nxt, cur;

    assign cyc_ok = req_valid && req_mem;

    regacc_win_match #(.ADDR_W(ADDR_W), .WIN_W(REG_WIN_W)) u_reg_win (
        .addr(req_addr), .base(cfg_reg_base), .hit(reg_hit), .offset(reg_off));

    regacc_win_match #(.ADDR_W(ADDR_W), .WIN_W(GFX_WIN_W)) u_gfx_win (
        .addr(req_addr), .base(cfg_gfx_base), .hit(gfx_hit), .offset(gfx_off));

    regacc_win_match #(.ADDR_W(ADDR_W), .WIN_W(TM_WIN_W)) u_tm_win (
        .addr(req_addr), .base(cfg_tm_base), .hit(tm_hit), .offset(tm_off));

    regacc_alias_gate #(
        .GFX_WIN_W(GFX_WIN_W), .ALIAS_W(ALIAS_W),
        .ALIAS_LO(ALIAS_LO), .FUNC_W(FUNC_W)
    ) u_alias (
        .cyc_ok(cyc_ok), .gfx_hit(gfx_hit), .gfx_off(gfx_off),
        .gfx_en(cfg_gfx_en), .gfx_mem_en(cfg_gfx_mem_en), .func(req_func),
        .write(req_write), .reg_en(cfg_reg_en),
        .match(al_match), .refuse(al_refuse), .alias_off(al_off));

    // Priority: direct, then alias (which may refuse), then thermal.
    always_comb begin
        nxt = '{path: PATH_NONE, offset: '0, allow: 1'b0, reject: 1'b0};
        if (cyc_ok && cfg_reg_en && reg_hit) begin
            nxt.path   = PATH_DIRECT;
            nxt.offset = OFF_W'(reg_off);
            nxt.allow  = 1'b1;
        end else if (al_match) begin
            if (al_refuse) begin
                nxt.reject = 1'b1;
            end else begin
                nxt.path   = PATH_ALIAS;
                nxt.offset = OFF_W'(al_off);
                nxt.allow  = 1'b1;
            end
        end else if (cyc_ok && tm_hit) begin
            nxt.path   = PATH_THERMAL;
            nxt.offset = OFF_W'(tm_off);
            nxt.allow  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '{path: PATH_NONE, offset: '0, allow: 1'b0, reject: 1'b0};
        end else begin
            cur <= nxt;
        end
    end

    assign out_sel    = cur.path;
    assign out_offset = cur.offset;
    assign out_allow  = cur.allow;
    assign out_reject = cur.reject;
endmodule

// File: rtl/regacc_decoder_chk.sv
module regacc_decoder_chk #(
    parameter int          ADDR_W    = 40,
    parameter int          REG_WIN_W = 15,
    parameter int          GFX_WIN_W = 22,
    parameter int          TM_WIN_W  = 12,
    parameter int          ALIAS_W   = 14,
    parameter logic [31:0] ALIAS_LO  = 32'h0001_0000,
    parameter int          FUNC_W    = 3,
    parameter int          OFF_W     = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_mem,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [FUNC_W-1:0] req_func,
    input logic              cfg_reg_en,
    input logic [ADDR_W-1:0] cfg_reg_base,
    input logic              cfg_gfx_en,
    input logic              cfg_gfx_mem_en,
    input logic [ADDR_W-1:0] cfg_gfx_base,
    input logic [ADDR_W-1:0] cfg_tm_base,
    input logic [1:0]        out_sel,
    input logic [OFF_W-1:0]  out_offset,
    input logic              out_allow,
    input logic              out_reject
);
    logic cyc;
    logic dhit;
    logic thit;
    logic gwin;

    assign cyc  = req_valid && req_mem;
    assign dhit = cyc && cfg_reg_en &&
                  (req_addr[ADDR_W-1:REG_WIN_W] == cfg_reg_base[ADDR_W-1:REG_WIN_W]);
    assign thit = cyc && (req_addr[ADDR_W-1:TM_WIN_W] == cfg_tm_base[ADDR_W-1:TM_WIN_W]);
    assign gwin = (req_addr[ADDR_W-1:GFX_WIN_W] == cfg_gfx_base[ADDR_W-1:GFX_WIN_W]) &&
                  (req_addr[GFX_WIN_W-1:ALIAS_W] == GFX_WIN_W'(ALIAS_LO) >> ALIAS_W);

    // R1
    direct_route_chk: assert property (@(posedge clk) disable iff (rst)
        dhit |=> (out_sel == 2'd1) && (out_offset == OFF_W'($past(req_addr[REG_WIN_W-1:0]))));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc |=> (out_sel == 2'd0) && !out_allow && !out_reject && (out_offset == '0));

    // R10
    excl_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_allow && out_reject));

    // R10
    allow_route_chk: assert property (@(posedge clk) disable iff (rst)
        out_allow == (out_sel != 2'd0));

    // R5
    reject_is_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_reject) |-> $past(req_write) && !$past(cfg_reg_en));

    // R6
    thermal_route_chk: assert property (@(posedge clk) disable iff (rst)
        (thit && !dhit && !gwin) |=> (out_sel == 2'd3) && out_allow);
endmodule

bind regacc_decoder regacc_decoder_chk #(
    .ADDR_W(ADDR_W), .REG_WIN_W(REG_WIN_W), .GFX_WIN_W(GFX_WIN_W),
    .TM_WIN_W(TM_WIN_W), .ALIAS_W(ALIAS_W), .ALIAS_LO(ALIAS_LO),
    .FUNC_W(FUNC_W), .OFF_W(OFF_W)
) u_chk (.*);

// File: tb/regacc_decoder_bench.sv
module regacc_decoder_bench;
    localparam int AW = 40;
    localparam int OW = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_mem = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]    req_func = '0;
    logic          cfg_reg_en = 1'b0, cfg_gfx_en = 1'b0, cfg_gfx_mem_en = 1'b0;
    logic [AW-1:0] cfg_reg_base = '0, cfg_gfx_base = '0, cfg_tm_base = '0;
    logic [1:0]    out_sel;
    logic [OW-1:0] out_offset;
    logic          out_allow, out_reject;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    regacc_decoder u_regacc_decoder (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_mem(req_mem), .req_write(req_write),
        .req_addr(req_addr), .req_func(req_func),
        .cfg_reg_en(cfg_reg_en), .cfg_reg_base(cfg_reg_base),
        .cfg_gfx_en(cfg_gfx_en), .cfg_gfx_mem_en(cfg_gfx_mem_en),
        .cfg_gfx_base(cfg_gfx_base), .cfg_tm_base(cfg_tm_base),
        .out_sel(out_sel), .out_offset(out_offset),
        .out_allow(out_allow), .out_reject(out_reject));

    task automatic check(input string tag, input logic [1:0] es, input logic [OW-1:0] eo,
                         input logic ea, input logic er);
        n_cmp++;
        if (out_sel !== es || out_offset !== eo || out_allow !== ea || out_reject !== er) begin
            n_bad++;
            $display("FAIL %s addr=%h: got sel=%0d off=%h allow=%b rej=%b, expected sel=%0d off=%h allow=%b rej=%b",
                     tag, req_addr, out_sel, out_offset, out_allow, out_reject, es, eo, ea, er);
        end
    endtask

    // Expected outcome built from R1..R8 arithmetic.
    task automatic expect_now(output logic [1:0] es, output logic [OW-1:0] eo,
                              output logic ea, output logic er, output string tag);
        logic          cyc, dh, am, th;
        logic [AW-1:0] goff;
        cyc  = req_valid && req_mem;
        dh   = cyc && cfg_reg_en && ((req_addr >> 15) == (cfg_reg_base >> 15));
        goff = req_addr - ((cfg_gfx_base >> 22) << 22);
        am   = cyc && cfg_gfx_en && cfg_gfx_mem_en && (req_func == 3'd0) &&
               ((req_addr >> 22) == (cfg_gfx_base >> 22)) &&
               (goff >= 40'h10000) && (goff <= 40'h13FFF);
        th   = cyc && ((req_addr >> 12) == (cfg_tm_base >> 12));
        es = 2'd0; eo = '0; ea = 1'b0; er = 1'b0; tag = "R8";
        if (dh) begin
            es = 2'd1; eo = OW'(req_addr % 40'h8000); ea = 1'b1;
            tag = (req_addr >= 40'h1_0000_0000) ? "R2" : "R1";
        end else if (am) begin
            if (req_write && !cfg_reg_en) begin
                er = 1'b1; tag = "R5";
            end else begin
                es = 2'd2; eo = OW'(goff - 40'h10000); ea = 1'b1; tag = "R3";
            end
        end else if (th) begin
            es = 2'd3; eo = OW'(req_addr % 40'h1000); ea = 1'b1; tag = "R6";
        end else if (cyc) begin
            tag = "R4";
        end
    endtask

    task automatic apply_and_check(input string extra);
        logic [1:0]    es;
        logic [OW-1:0] eo;
        logic          ea, er;
        string         tag;
        expect_now(es, eo, ea, er, tag);
        @(negedge clk);
        check({tag, extra}, es, eo, ea, er);
    endtask

    task automatic sweep(input logic [AW-1:0] rb, input logic [AW-1:0] gb,
                         input logic [AW-1:0] tb_, input string extra);
        logic [AW-1:0] addrs [10];
        cfg_reg_base = rb; cfg_gfx_base = gb; cfg_tm_base = tb_;
        addrs[0] = rb + 40'h1234;  addrs[1] = rb + 40'h7FFF;
        addrs[2] = gb + 40'h10000; addrs[3] = gb + 40'h13FFF;
        addrs[4] = gb + 40'h0FFFF; addrs[5] = gb + 40'h14000;
        addrs[6] = tb_ + 40'h0AC;  addrs[7] = tb_ + 40'hFFF;
        addrs[8] = tb_ + 40'h1000; addrs[9] = 40'h0;
        for (int c = 0; c < 128; c++) begin
            for (int a = 0; a < 10; a++) begin
                @(negedge clk);
                req_valid      = c[0];
                req_mem        = c[1];
                req_write      = c[2];
                cfg_reg_en     = c[3];
                cfg_gfx_en     = c[4];
                cfg_gfx_mem_en = c[5];
                req_func       = c[6] ? 3'd1 : 3'd0;
                req_addr       = addrs[a];
                apply_and_check(extra);
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired: got running, expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R9: reset state, even with a hitting request present
        cfg_reg_en = 1'b1; cfg_reg_base = 40'h1_0000_8000;
        req_valid = 1'b1; req_mem = 1'b1; req_addr = 40'h1_0000_8010;
        repeat (3) @(negedge clk);
        check("R9 reset", 2'd0, '0, 1'b0, 1'b0);
        @(negedge clk); rst = 1'b0;
        // R9: one-cycle latency — result appears after the first edge
        @(negedge clk);
        check("R9 latency R2", 2'd1, 15'h0010, 1'b1, 1'b0);

        // R10: refused alias write rejects for exactly one cycle
        cfg_reg_en = 1'b0; cfg_gfx_en = 1'b1; cfg_gfx_mem_en = 1'b1;
        cfg_gfx_base = 40'hD000_0000; req_func = 3'd0;
        req_write = 1'b1; req_addr = 40'hD001_0040;
        @(negedge clk);
        check("R10 reject", 2'd0, '0, 1'b0, 1'b1);
        req_write = 1'b0;
        @(negedge clk);
        check("R10 read after reject R5", 2'd2, 15'h0040, 1'b1, 1'b0);
        req_valid = 1'b0;
        @(negedge clk);
        check("R10 reject gone R8", 2'd0, '0, 1'b0, 1'b0);

        // Separated layout, register base above 4 GB (R2)
        sweep(40'h1_0000_8000, 40'hD000_0000, 40'hFED0_8000, " sep");
        // Overlapping layout: register and thermal bases inside alias window (R7)
        sweep(40'hE001_0000, 40'hE000_0000, 40'hE001_2000, " R7 overlap");
        // Thermal inside alias window, register base elsewhere (R7 refused write)
        sweep(40'h0800_0000, 40'hE000_0000, 40'hE001_3000, " R7 alias-thermal");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule